// File: doc/BRIEF.md
# Receive Frame Length Count FIFO

This block measures how many bytes each received frame carried and keeps those lengths in a short queue, so that software can collect them after the data itself has moved on. A down-counter runs during each frame. It starts from a programmable limit and loses one per received byte. When the frame ends, the number of bytes seen is pushed into a four-entry queue, and the counter starts again from the current limit for the next frame.

When a length arrives while the queue is full, the newest slot is overwritten in place and marked as an overflow entry. The three older entries are kept unmarked. The overflow indication stays hidden until the reader has taken those three older lengths and the marked entry sits at the head. From then on the indication is sticky. Only the clear command removes it, and that command also empties the queue. A receive purge reloads the counter from the limit without touching the queue.

Top module: `rx_frame_len_queue`

## Requirements
- R1: After reset, `len_avail` is 0, `ovf_status` is 0 and `head_count` is 0.
- R2: On `frame_end`, the queue receives the number of bytes strobed since the counter was last loaded. The counter is then loaded from the `limit` value present in that cycle, so a new limit takes effect at the next frame.
- R3: The counter saturates at zero. A frame with more bytes than the limit records the limit, and a limit of 0 records 0.
- R4: Lengths are read oldest first. `head_count` shows the oldest unread length, and `len_avail` is 1 whenever at least one length is stored.
- R5: The queue holds exactly four lengths. A push while four are stored and no read is accepted overwrites the fourth (newest) entry and tags it as overflow. A push in the same cycle as an accepted read on a full queue is a normal push.
- R6: The three older entries are never tagged. `ovf_status` stays 0 until reads have brought the tagged entry to the head, and it can only rise in the cycle after a read.
- R7: Once `ovf_status` is 1, it stays 1 through further reads and pushes until `clear_cmd`.
- R8: `clear_cmd` empties the queue and clears `len_avail` and `ovf_status`. It takes priority over a push or read in the same cycle.
- R9: `reload_cmd` loads the counter from `limit` and discards the bytes counted so far. It leaves the stored lengths untouched, and it takes priority over a byte strobe in the same cycle.
- R10: A read with the queue empty changes nothing. `head_count` keeps showing the last length read, and `len_avail` stays 0.
- R11: A byte strobe in the same cycle as `frame_end` is counted in the ending frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| byte_stb | input | 1 | One received byte this cycle |
| frame_end | input | 1 | Current frame ends this cycle; push its length |
| limit | input | CNT_W | Counter start value |
| reload_cmd | input | 1 | Reload the counter from `limit` (receive purge) |
| clear_cmd | input | 1 | Empty the queue and clear overflow status |
| rd_stb | input | 1 | Pop the head length |
| head_count | output | CNT_W | Oldest stored length, or last length read when empty |
| len_avail | output | 1 | At least one length is stored |
| ovf_status | output | 1 | Sticky overflow indication |

## Verification
The assertions assume that each strobe is a one-cycle level sampled at the clock edge. They also assume that `limit` is steady in the cycle after a reload, since the reload check compares the counter with the previous limit. The reset check assumes that no frame ends in the first cycle after reset, while the counter takes its first load. The stimulus drives every input just after a rising edge, pulses strobes for one cycle, and changes `limit` only between reloads or frames. It waits two cycles after reset before any traffic.

// File: rtl/flq_pkg.sv
package flq_pkg;

  // Where the remaining-count register takes its next value from.
  typedef enum logic [1:0] {
    SRC_HOLD  = 2'd0,
    SRC_DEC   = 2'd1,
    SRC_LIMIT = 2'd2
  } load_src_e;

endpackage

// File: rtl/flq_counter.sv
module flq_counter
  import flq_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             byte_stb,
  input  logic             frame_end,
  input  logic             reload_cmd,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] frame_len,
  output logic [CNT_W-1:0] rem_o,
  output logic [CNT_W-1:0] lim_o
);

  // Step down by one and stop at zero.
  function automatic logic [CNT_W-1:0] sat_dec(input logic [CNT_W-1:0] v);
    return (v == '0) ? v : v - CNT_W'(1);
  endfunction

  // Bytes seen = loaded start value minus what remains.
  function automatic logic [CNT_W-1:0] len_of(input logic [CNT_W-1:0] start,
                                              input logic [CNT_W-1:0] left);
    return start - left;
  endfunction

  logic [CNT_W-1:0] rem_q, lim_q, rem_after;
  logic             need_load_q;
  load_src_e        src;

  always_comb begin
    if (need_load_q || reload_cmd || frame_end) src = SRC_LIMIT;
    else if (byte_stb)                          src = SRC_DEC;
    else                                        src = SRC_HOLD;
  end

  // The byte of the ending cycle belongs to the ending frame.
  assign rem_after = byte_stb ? sat_dec(rem_q) : rem_q;
  assign frame_len = len_of(lim_q, rem_after);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q       <= '0;
      lim_q       <= '0;
      need_load_q <= 1'b1;
    end else begin
      need_load_q <= 1'b0;
      unique case (src)
        SRC_LIMIT: begin
          rem_q <= limit;
          lim_q <= limit;
        end
        SRC_DEC:   rem_q <= sat_dec(rem_q);
        default:   rem_q <= rem_q;
      endcase
    end
  end

  assign rem_o = rem_q;
  assign lim_o = lim_q;

endmodule

// File: rtl/flq_store.sv
module flq_store #(
  parameter int DEPTH = 4,
  parameter int CNT_W = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        push,
  input  logic [CNT_W-1:0]            push_val,
  input  logic                        pop_req,
  input  logic                        clear,
  output logic [CNT_W-1:0]            head_val,
  output logic                        head_tag,
  output logic                        avail,
  output logic                        ovf_status,
  output logic [$clog2(DEPTH+1)-1:0]  occ_o
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int OW = $clog2(DEPTH + 1);

  function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
    return (int'(p) == DEPTH - 1) ? '0 : p + PW'(1);
  endfunction

  function automatic logic [PW-1:0] ptr_prev(input logic [PW-1:0] p);
    return (p == '0) ? PW'(DEPTH - 1) : p - PW'(1);
  endfunction

  logic [CNT_W-1:0] slot_val [DEPTH];
  logic [DEPTH-1:0] slot_tag;
  logic [PW-1:0]    wr_ptr, rd_ptr, wsel;
  logic [OW-1:0]    occ_q;
  logic [CNT_W-1:0] last_q;
  logic             sticky_q;
  logic             full, do_pop, ovr, app, wr_en;

  assign full   = (occ_q == OW'(DEPTH));
  assign do_pop = pop_req && (occ_q != '0);
  assign ovr    = push && full && !do_pop;   // overwrite newest slot
  assign app    = push && !ovr;              // ordinary append
  assign wsel   = ovr ? ptr_prev(wr_ptr) : wr_ptr;
  assign wr_en  = push && !clear;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_val[i] <= '0;
        slot_tag[i] <= 1'b0;
      end else if (wr_en && (wsel == PW'(i))) begin
        slot_val[i] <= push_val;
        slot_tag[i] <= ovr;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      occ_q    <= '0;
      last_q   <= '0;
      sticky_q <= 1'b0;
    end else if (clear) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      occ_q    <= '0;
      sticky_q <= 1'b0;
    end else begin
      if (do_pop) begin
        rd_ptr <= ptr_next(rd_ptr);
        last_q <= slot_val[rd_ptr];
      end
      if (app) wr_ptr <= ptr_next(wr_ptr);
      occ_q    <= occ_q + OW'(app) - OW'(do_pop);
      sticky_q <= sticky_q | head_tag;
    end
  end

  assign avail      = (occ_q != '0);
  assign head_tag   = avail && slot_tag[rd_ptr];
  assign head_val   = avail ? slot_val[rd_ptr] : last_q;
  assign ovf_status = sticky_q | head_tag;
  assign occ_o      = occ_q;

endmodule

// File: rtl/rx_frame_len_queue.sv
module rx_frame_len_queue #(
  parameter int CNT_W = 16,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             byte_stb,
  input  logic             frame_end,
  input  logic [CNT_W-1:0] limit,
  input  logic             reload_cmd,
  input  logic             clear_cmd,
  input  logic             rd_stb,
  output logic [CNT_W-1:0] head_count,
  output logic             len_avail,
  output logic             ovf_status
);

  localparam int OW = $clog2(DEPTH + 1);

  // Internal events brought out by name for the checker.
  logic [CNT_W-1:0] frame_len;
  logic [CNT_W-1:0] c_rem, c_lim;
  logic [OW-1:0]    q_occ;
  logic             head_tag;

  flq_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .byte_stb   (byte_stb),
    .frame_end  (frame_end),
    .reload_cmd (reload_cmd),
    .limit      (limit),
    .frame_len  (frame_len),
    .rem_o      (c_rem),
    .lim_o      (c_lim)
  );

  flq_store #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .push       (frame_end),
    .push_val   (frame_len),
    .pop_req    (rd_stb),
    .clear      (clear_cmd),
    .head_val   (head_count),
    .head_tag   (head_tag),
    .avail      (len_avail),
    .ovf_status (ovf_status),
    .occ_o      (q_occ)
  );

endmodule

// File: rtl/rx_frame_len_queue_chk.sv
module rx_frame_len_queue_chk #(
  parameter int CNT_W = 16,
  parameter int DEPTH = 4,
  parameter int OW    = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frame_end,
  input logic             reload_cmd,
  input logic             clear_cmd,
  input logic             rd_stb,
  input logic [CNT_W-1:0] limit,
  input logic [CNT_W-1:0] head_count,
  input logic             len_avail,
  input logic             ovf_status,
  input logic [OW-1:0]    q_occ,
  input logic [CNT_W-1:0] c_rem,
  input logic [CNT_W-1:0] c_lim
);

  // R5
  occ_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(q_occ) <= DEPTH);

  // R3
  rem_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    c_rem <= c_lim);

  // R8
  clear_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear_cmd |=> (!len_avail && !ovf_status));

  // R7
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_status && !clear_cmd) |=> ovf_status);

  // R6
  ovf_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_status) |-> $past(rd_stb));

  // R4
  push_avail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && !clear_cmd) |=> len_avail);

  // R10
  rd_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !len_avail && !frame_end && !clear_cmd) |=>
      ($stable(head_count) && !len_avail));

  // R9
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reload_cmd |=> (c_rem == $past(limit)));

endmodule

bind rx_frame_len_queue rx_frame_len_queue_chk #(
  .CNT_W(CNT_W), .DEPTH(DEPTH), .OW(OW)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .frame_end  (frame_end),
  .reload_cmd (reload_cmd),
  .clear_cmd  (clear_cmd),
  .rd_stb     (rd_stb),
  .limit      (limit),
  .head_count (head_count),
  .len_avail  (len_avail),
  .ovf_status (ovf_status),
  .q_occ      (q_occ),
  .c_rem      (c_rem),
  .c_lim      (c_lim)
);

// File: tb/rx_frame_len_queue_bench.sv
module rx_frame_len_queue_bench;

  localparam int CNT_W = 16;
  localparam int NVEC  = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             byte_stb = 1'b0, frame_end = 1'b0, reload_cmd = 1'b0;
  logic             clear_cmd = 1'b0, rd_stb = 1'b0;
  logic [CNT_W-1:0] limit = '0;
  logic [CNT_W-1:0] head_count;
  logic             len_avail, ovf_status;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rx_frame_len_queue #(.CNT_W(CNT_W), .DEPTH(4)) u_rx_frame_len_queue (
    .clk(clk), .rst_n(rst_n), .byte_stb(byte_stb), .frame_end(frame_end),
    .limit(limit), .reload_cmd(reload_cmd), .clear_cmd(clear_cmd),
    .rd_stb(rd_stb), .head_count(head_count), .len_avail(len_avail),
    .ovf_status(ovf_status)
  );

  // {limit, bytes in frame, expected length}
  localparam logic [47:0] VEC [NVEC] = '{
    {16'd10,    16'd3,  16'd3},
    {16'd5,     16'd5,  16'd5},
    {16'd4,     16'd9,  16'd4},
    {16'd1,     16'd0,  16'd0},
    {16'hFFFF,  16'd2,  16'd2},
    {16'd0,     16'd3,  16'd0},
    {16'd7,     16'd1,  16'd1},
    {16'd20,    16'd20, 16'd20}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One clock with the given strobes; inputs change 1 ns after the edge.
  task automatic cyc(input logic b, input logic f, input logic r,
                     input logic c, input logic d);
    byte_stb = b; frame_end = f; reload_cmd = r; clear_cmd = c; rd_stb = d;
    @(posedge clk); #1;
    byte_stb = 0; frame_end = 0; reload_cmd = 0; clear_cmd = 0; rd_stb = 0;
  endtask

  task automatic frame(input int n);
    for (int k = 0; k < n; k++) cyc(1, 0, 0, 0, 0);
    cyc(0, 1, 0, 0, 0);
  endtask

  task automatic rd();
    cyc(0, 0, 0, 0, 1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    limit = 16'd100;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    @(posedge clk); #1;
    // R1 reset state
    chk("R1 avail", len_avail, 0);
    chk("R1 ovf", ovf_status, 0);
    chk("R1 head", head_count, 0);

    // Table walk: R2 / R3 / R9 lengths
    for (int v = 0; v < NVEC; v++) begin
      limit = VEC[v][47:32];
      cyc(0, 0, 1, 0, 0);
      frame(int'(VEC[v][31:16]));
      chk("R3 table length", head_count, int'(VEC[v][15:0]));
      chk("R4 table avail", len_avail, 1);
      rd();
      chk("R4 table drained", len_avail, 0);
    end

    // R4 ordering
    limit = 16'd100;
    cyc(0, 0, 1, 0, 0);
    frame(1); frame(2); frame(3);
    chk("R4 first", head_count, 1); rd();
    chk("R4 second", head_count, 2); rd();
    chk("R4 third", head_count, 3); rd();
    chk("R4 empty", len_avail, 0);

    // R5 / R6 / R7 overflow
    frame(1); frame(2); frame(3); frame(4); frame(5);
    chk("R6 hidden at 5 pushes", ovf_status, 0);
    chk("R5 head", head_count, 1); rd();
    chk("R6 hidden after 1 read", ovf_status, 0); rd();
    chk("R6 hidden after 2 reads", ovf_status, 0);
    chk("R4 head third", head_count, 3); rd();
    chk("R5 overwritten fourth", head_count, 5);
    chk("R7 visible", ovf_status, 1); rd();
    chk("R7 sticky after read", ovf_status, 1);
    chk("R5 empty after four", len_avail, 0);
    // R10 read while empty
    rd();
    chk("R10 head held", head_count, 5);
    chk("R10 avail", len_avail, 0);
    chk("R10 ovf held", ovf_status, 1);
    frame(2);
    chk("R7 sticky after push", ovf_status, 1);
    // R8 clear
    cyc(0, 0, 0, 1, 0);
    chk("R8 avail", len_avail, 0);
    chk("R8 ovf", ovf_status, 0);
    // R8 priority over push
    cyc(1, 1, 0, 1, 0);
    chk("R8 clear beats push", len_avail, 0);
    cyc(0, 0, 1, 0, 0);

    // R5 read and push in one cycle on a full queue
    frame(1); frame(2); frame(3); frame(4);
    for (int k = 0; k < 4; k++) cyc(1, 0, 0, 0, 0);
    cyc(1, 1, 0, 0, 1);
    chk("R5 no overflow on pop+push", ovf_status, 0);
    chk("R5 head after pop", head_count, 2); rd(); rd(); rd();
    chk("R5 newest kept", head_count, 5);
    chk("R5 newest untagged", ovf_status, 0); rd();
    chk("R5 drained", len_avail, 0);

    // R11 byte on frame_end cycle
    cyc(1, 0, 0, 0, 0); cyc(1, 0, 0, 0, 0); cyc(1, 1, 0, 0, 0);
    chk("R11 length", head_count, 3); rd();

    // R9 reload mid-frame, queue untouched
    frame(1);
    for (int k = 0; k < 4; k++) cyc(1, 0, 0, 0, 0);
    cyc(1, 0, 1, 0, 0);
    chk("R9 queue kept", head_count, 1);
    cyc(1, 0, 0, 0, 0); cyc(1, 0, 0, 0, 0); cyc(0, 1, 0, 0, 0);
    rd();
    chk("R9 restarted count", head_count, 2); rd();

    // R2 limit change takes effect at the next frame
    limit = 16'd3;
    frame(5);
    chk("R2 old limit frame", head_count, 5); rd();
    frame(5);
    chk("R2 new limit frame", head_count, 3); rd();
    chk("R2 drained", len_avail, 0);

    finish_run();
  end

endmodule